// File: doc/BRIEF.md
# Vector Byte-LSB Parity Unit

This execution unit takes one 128-bit vector operand and, for each lane, returns the parity of bit 0 of every byte in that lane. Lanes are 32-bit words, 64-bit doublewords or the whole 128-bit quadword. A 5-bit sub-operation selector, decoded from the instruction, picks the lane width. Each lane's parity lands in bit 0 of that lane, and every other bit of the lane is cleared. In quadword form the single parity bit sits in bit 0 of the low doubleword, and the high doubleword is all zero.

The issue logic presents an operation only when the shared opcode has already matched. The unit registers its answer once. The result flag pulses one clock after the input strobe, and the result stays on the outputs until the next operation is captured. A selector value that names none of the three forms gives a zero result with the illegal flag set.

Bits are numbered little-endian. Bit 0 is the least significant bit of the vector, and byte k occupies bits 8k+7 down to 8k.

Top module: `vpar_unit`

## Requirements
- R1: Selector 8 (word form): for lane i in 0..3, res_o bit 32i is the XOR of bit 0 of bytes 4i..4i+3, and all other result bits are 0.
- R2: Selector 9 (doubleword form): for lane j in 0..1, res_o bit 64j is the XOR of bit 0 of bytes 8j..8j+7, and all other result bits are 0.
- R3: Selector 10 (quadword form): res_o bit 0 is the XOR of bit 0 of all sixteen bytes, and bits 127..1 are 0, including the entire upper doubleword.
- R4: Bits 1 to 7 of every byte of src_i have no effect on res_o in any form.
- R5: Any selector value other than 8, 9 or 10 gives illegal_o = 1 and res_o = 0. The three legal values give illegal_o = 0.
- R6: res_valid_o is 1 exactly one clock after a cycle with valid_i = 1, and 0 after a cycle with valid_i = 0.
- R7: While valid_i is 0, res_o and illegal_o keep their values, whatever src_i and sel_i do.
- R8: Asserting rst_ni low clears res_o, res_valid_o and illegal_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; the shared opcode has matched |
| src_i | input | 128 | Source vector |
| sel_i | input | 5 | Sub-operation selector (8 word, 9 doubleword, 10 quadword) |
| res_o | output | 128 | Registered result vector |
| res_valid_o | output | 1 | Result strobe, one clock after valid_i |
| illegal_o | output | 1 | Registered flag for an unrecognised selector |

## Verification
The assertions check on every cycle that the decoder selects exactly one outcome. They also check that no bit outside a lane's bit 0 is ever set, that an illegal flag comes with a zero result, the one-cycle strobe latency, and that the outputs hold between operations. Only the bench scenarios can show that each parity value is correct for its lane and form, and that bits 1 to 7 of each byte are ignored. The bench covers these with zero, all-ones, single-bit and pseudo-random sources, and it sweeps every selector value. Reset clearing is also shown only by the bench.

// File: rtl/vpar_pkg.sv
package vpar_pkg;
  parameter int unsigned SEL_W = 5;

  localparam logic [SEL_W-1:0] SEL_WORD  = SEL_W'(8);
  localparam logic [SEL_W-1:0] SEL_DWORD = SEL_W'(9);
  localparam logic [SEL_W-1:0] SEL_QUAD  = SEL_W'(10);

  typedef struct packed {
    logic word_en;
    logic dword_en;
    logic quad_en;
    logic illegal;
  } vpar_mode_t;
endpackage

// File: rtl/vpar_decode.sv
module vpar_decode
  import vpar_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output vpar_mode_t       mode_o
);
  always_comb begin
    mode_o = '0;
    unique case (sel_i)
      SEL_WORD:  mode_o.word_en  = 1'b1;
      SEL_DWORD: mode_o.dword_en = 1'b1;
      SEL_QUAD:  mode_o.quad_en  = 1'b1;
      default:   mode_o.illegal  = 1'b1;
    endcase
  end
endmodule

// File: rtl/vpar_tree.sv
module vpar_tree #(
  parameter int unsigned NUM_BYTES = 16,
  parameter int unsigned BPW       = 4,
  localparam int unsigned NUM_WORDS = NUM_BYTES / BPW,
  localparam int unsigned NUM_DW    = NUM_WORDS / 2
) (
  input  logic [NUM_BYTES-1:0] lsb_i,
  output logic [NUM_WORDS-1:0] word_par_o,
  output logic [NUM_DW-1:0]    dword_par_o,
  output logic                 quad_par_o
);
  // word parities feed doubleword, doublewords feed quad
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_par_o[w] = ^lsb_i[w*BPW +: BPW];
  end
  for (genvar d = 0; d < NUM_DW; d++) begin : g_dword
    assign dword_par_o[d] = word_par_o[2*d] ^ word_par_o[2*d+1];
  end
  assign quad_par_o = ^dword_par_o;
endmodule

// File: rtl/vpar_out_reg.sv
module vpar_out_reg #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] res_d_i,
  input  logic             ill_d_i,
  output logic [VEC_W-1:0] res_o,
  output logic             res_valid_o,
  output logic             illegal_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= res_d_i;
        illegal_o <= ill_d_i;
      end
    end
  end

  p_valid_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);
  p_valid_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(illegal_o)));
endmodule

// File: rtl/vpar_unit.sv
module vpar_unit
  import vpar_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NUM_BYTES = VEC_W / BYTE_W,
  localparam int unsigned BPW       = WORD_W / BYTE_W,
  localparam int unsigned NUM_WORDS = VEC_W / WORD_W,
  localparam int unsigned NUM_DW    = NUM_WORDS / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [VEC_W-1:0] res_o,
  output logic             res_valid_o,
  output logic             illegal_o
);
  vpar_mode_t            mode;
  logic [NUM_BYTES-1:0]  lsb;
  logic [NUM_WORDS-1:0]  word_par;
  logic [NUM_DW-1:0]     dword_par;
  logic                  quad_par;
  logic [NUM_WORDS-1:0]  lane_bit;
  logic [VEC_W-1:0]      res_d;
  logic [VEC_W-1:0]      lane_mask;
  logic                  unused_upper_bits;

  vpar_decode u_decode (
    .sel_i  (sel_i),
    .mode_o (mode)
  );

  // only bit 0 of each byte enters the parity
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lsb
    assign lsb[b] = src_i[b*BYTE_W];
  end

  always_comb begin
    lane_mask = '0;
    for (int i = 0; i < NUM_WORDS; i++) lane_mask[i*WORD_W] = 1'b1;
  end
  assign unused_upper_bits = ^(src_i & ~{NUM_BYTES{{(BYTE_W-1){1'b0}}, 1'b1}});

  vpar_tree #(
    .NUM_BYTES (NUM_BYTES),
    .BPW       (BPW)
  ) u_tree (
    .lsb_i       (lsb),
    .word_par_o  (word_par),
    .dword_par_o (dword_par),
    .quad_par_o  (quad_par)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_lane
    if (i == 0) begin : g_lane0
      assign lane_bit[i] = (mode.word_en  & word_par[i])
                         | (mode.dword_en & dword_par[0])
                         | (mode.quad_en  & quad_par);
    end else if (i % 2 == 0) begin : g_even
      assign lane_bit[i] = (mode.word_en  & word_par[i])
                         | (mode.dword_en & dword_par[i/2]);
    end else begin : g_odd
      assign lane_bit[i] = mode.word_en & word_par[i];
    end
  end

  always_comb begin
    res_d = '0;
    for (int i = 0; i < NUM_WORDS; i++) res_d[i*WORD_W] = lane_bit[i];
  end

  vpar_out_reg #(
    .VEC_W (VEC_W)
  ) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .res_d_i     (res_d),
    .ill_d_i     (mode.illegal),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .illegal_o   (illegal_o)
  );

  p_one_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({mode.word_en, mode.dword_en, mode.quad_en, mode.illegal}));
  p_illegal_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (res_o == '0));
  p_zero_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o & ~lane_mask) == '0);
  p_quad_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode.quad_en) |=> (res_o[VEC_W-1:1] == '0));
endmodule

// File: tb/tb_vpar_unit.sv
`timescale 1ns/1ps
module tb_vpar_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [4:0]   sel_i = '0;
  logic [127:0] res_o;
  logic         res_valid_o;
  logic         illegal_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vpar_unit dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .src_i       (src_i),
    .sel_i       (sel_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .illegal_o   (illegal_o)
  );

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [127:0] s, input logic [4:0] sel,
                                output logic [127:0] r, output logic ill);
    r = '0;
    ill = 1'b0;
    for (int k = 0; k < 16; k++) begin
      case (sel)
        5'd8:    r[32*(k/4)] = r[32*(k/4)] ^ s[8*k];
        5'd9:    r[64*(k/8)] = r[64*(k/8)] ^ s[8*k];
        5'd10:   r[0]        = r[0] ^ s[8*k];
        default: ill = 1'b1;
      endcase
    end
    if (ill) r = '0;
  endfunction

  logic [127:0] last_res;
  logic         last_ill;

  task automatic run_op(input logic [127:0] s, input logic [4:0] sel, input string req);
    logic [127:0] er;
    logic ei;
    model(s, sel, er, ei);
    @(negedge clk_i);
    src_i = s; sel_i = sel; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({127'd0, res_valid_o}, 128'd1, "R6 strobe");
    chk(res_o, er, req);
    chk({127'd0, illegal_o}, {127'd0, ei}, "R5 flag");
    last_res = er;
    last_ill = ei;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] lfsr;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(res_o, '0, "R8 res");
    chk({126'd0, res_valid_o, illegal_o}, '0, "R8 flags");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({127'd0, res_valid_o}, '0, "R6 idle");

    for (int m = 8; m <= 10; m++) begin
      string req;
      req = (m == 8) ? "R1" : (m == 9) ? "R2" : "R3";
      run_op('0, 5'(m), req);
      run_op({128{1'b1}}, 5'(m), req);
      for (int k = 0; k < 16; k++) run_op(128'd1 << (8*k), 5'(m), req);
      // R4: upper bits of each byte must not matter
      for (int k = 0; k < 16; k++)
        for (int b = 1; b < 8; b++) begin
          run_op(128'd1 << (8*k + b), 5'(m), "R4");
          run_op((128'd1 << (8*k + b)) | (128'd1 << (8*k)), 5'(m), "R4");
        end
    end

    lfsr = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[126:0], lfsr[127] ^ lfsr[125] ^ lfsr[100] ^ lfsr[98]};
      run_op(lfsr, 5'd8, "R1");
      run_op(lfsr, 5'd9, "R2");
      run_op(lfsr, 5'd10, "R3");
    end

    // R5 full selector sweep
    for (int s = 0; s < 32; s++) begin
      run_op(128'h0100_0000_0000_0001_0000_0001_0000_0001, 5'(s), "R5 sel sweep");
      run_op({128{1'b1}} ^ 128'h1, 5'(s), "R5 sel sweep");
    end

    // R7 hold while valid_i low
    run_op(128'h1, 5'd8, "R1");
    @(negedge clk_i);
    src_i = {128{1'b1}}; sel_i = 5'd3;
    chk({127'd0, res_valid_o}, '0, "R6 idle");
    chk(res_o, last_res, "R7 hold");
    @(negedge clk_i);
    src_i = '0; sel_i = 5'd10;
    @(negedge clk_i);
    chk(res_o, last_res, "R7 hold");
    chk({127'd0, illegal_o}, {127'd0, last_ill}, "R7 flag hold");
    run_op('0, 5'd31, "R5");
    @(negedge clk_i);
    sel_i = 5'd8; src_i = 128'h1;
    @(negedge clk_i);
    chk({127'd0, illegal_o}, 128'd1, "R7 flag hold");
    chk(res_o, '0, "R7 hold");

    // R8 mid-run reset
    run_op(128'h1_0000_0001, 5'd8, "R1");
    @(negedge clk_i);
    src_i = 128'h1; sel_i = 5'd8; valid_i = 1'b1;
    rst_ni = 1'b0;
    #1;
    chk(res_o, '0, "R8 res");
    chk({126'd0, res_valid_o, illegal_o}, '0, "R8 flags");
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(res_o, '0, "R8 res after release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule